// File: doc/BRIEF.md
# ECG Acquisition Front-End SPI Mock

This block stands in for an eight-channel biopotential acquisition chip, so that an acquisition controller can be brought up and tested without the analog board. It is a synthesizable SPI slave in the system clock domain. SCLK, MOSI and the active-low chip select are resynchronised and their edges detected. The block keeps a bank of 26 byte-wide configuration registers. A controller can read or write any run of consecutive registers with one command.

A start command switches on continuous acquisition. A data-ready output then pulses low once per sample period, and each pulse latches a fresh synthetic frame. The controller clocks out the frame on MISO while chip select is low. Standby and wakeup commands put the mock to sleep and bring it back, and each transition takes a fixed number of cycles. During those cycles the mock ignores commands, as the real device would.

Top module: `ecgm_spi_mock`

## Requirements
- R1: After reset, `dataReadyN` is high, `spiMiso` is low, register 0 reads 0xD2, and every other register at address a (1..25) reads 0x40 OR a.
- R2: Bytes are MSB first. MOSI is captured on each falling SCLK edge while `spiCsN` is low, and MISO changes after each rising edge. While `spiCsN` is high, MISO is low. Raising `spiCsN` restarts byte alignment and abandons any command that is half received.
- R3: A write command is the byte 0x40 OR a (a = 5-bit start address), then a count byte holding n-1, then n data bytes. The data bytes are stored at addresses a, a+1, ..., and the address advances modulo 32.
- R4: A read command is the byte 0x20 OR a, then a count byte holding n-1. During the next n byte slots, MISO returns the registers at a, a+1, ... in order. MOSI is ignored during those n slots.
- R5: Register 0 is a read-only identifier (0xD2), so writes to it have no effect. Addresses 26 to 31 read as 0x00, and writes to them are discarded.
- R6: Opcode 0x06 restores every register to its R1 value and stops continuous acquisition.
- R7: Opcode 0x10 starts continuous acquisition. From then on, `dataReadyN` goes low for exactly one clock cycle every SAMPLE_PERIOD cycles. Opcode 0x11 stops the pulses.
- R8: Each data-ready pulse latches a 27-byte frame numbered s (0 for the first pulse after a start, then counting up modulo 256). The frame is read with chip select low while no register command is in progress:
  - Bytes 0 to 2: 0xC0, 0x00, s.
  - Bytes 3 to 26: for channel c = 0..7, the three bytes 0xA0+c, s and 16c+5.
  - Any byte slot after the 27th returns 0x00.
- R9: Opcode 0x04 starts standby, which takes ENTER_LAT cycles to enter. No data-ready pulses occur once standby is reached. From the standby byte on, every byte except the wakeup opcode 0x02 is ignored.
- R10: After the wakeup byte, commands remain ignored for WAKE_LAT cycles. After that, commands are accepted again, and if acquisition was running, data-ready pulses resume.
- R11: Any opcode not listed above is ignored, and the byte after it is decoded as a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiClk | input | 1 | SPI serial clock from the controller |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | Serial data from the controller |
| spiMiso | output | 1 | Serial data to the controller |
| dataReadyN | output | 1 | Active-low one-cycle pulse when a new frame is ready |

## Verification
The hardest behaviour to reach from the ports is the set of latency windows around standby. A command has to arrive while the mock is entering standby, while it is asleep, and while it is still waking up, and each of these must be shown to have no effect. The bench issues standby just after a data-ready pulse, so that no sample period boundary falls inside the entry window. It then writes a register while the mock is asleep. It sends wakeup and, in the same burst of traffic, a second register write that lands inside the wake window. Once the wake latency has passed, it reads both registers back and expects their old values. It then confirms that pulses resume and that a new write succeeds.

// File: rtl/ecgm_pkg.sv
package ecgm_pkg;

  localparam int REG_COUNT   = 26;
  localparam int ADDR_W      = 5;
  localparam int FRAME_BYTES = 27;
  localparam int IDX_W       = $clog2(FRAME_BYTES + 1);
  localparam int SYNC_STAGES = 2;

  localparam logic [7:0] OP_WAKE  = 8'h02;
  localparam logic [7:0] OP_SLEEP = 8'h04;
  localparam logic [7:0] OP_RESET = 8'h06;
  localparam logic [7:0] OP_START = 8'h10;
  localparam logic [7:0] OP_STOP  = 8'h11;
  localparam logic [2:0] OP_RREG_HI = 3'b001;
  localparam logic [2:0] OP_WREG_HI = 3'b010;
  localparam logic [7:0] ID_VALUE = 8'hD2;

  typedef enum logic [1:0] {SRC_ZERO, SRC_REG, SRC_FRAME} txSrc_e;
  typedef enum logic [1:0] {PWR_ON, PWR_ENTER, PWR_SLEEP, PWR_WAKE} pwr_e;

  typedef struct packed {
    logic              loadTx;
    logic              shiftTx;
    logic              csActive;
    txSrc_e            txSrc;
    logic [ADDR_W-1:0] regAddr;
    logic [IDX_W-1:0]  frameIdx;
    logic              regWr;
    logic [7:0]        wrData;
    logic              regReset;
    logic              frameLatch;
    logic              sampleClr;
  } ctrlStb_t;

  function automatic logic [7:0] regDefault(input logic [ADDR_W-1:0] a);
    return (a == '0) ? ID_VALUE : (8'h40 | {{(8-ADDR_W){1'b0}}, a});
  endfunction

  function automatic logic [7:0] frameByte(input logic [IDX_W-1:0] idx,
                                           input logic [7:0] s);
    logic [IDX_W-1:0] off;
    logic [2:0]       ch;
    logic [1:0]       part;
    off  = idx - IDX_W'(3);
    ch   = 3'(off / IDX_W'(3));
    part = 2'(off % IDX_W'(3));
    if (idx == IDX_W'(0))                return 8'hC0;
    else if (idx == IDX_W'(1))           return 8'h00;
    else if (idx == IDX_W'(2))           return s;
    else if (idx >= IDX_W'(FRAME_BYTES)) return 8'h00;
    else begin
      case (part)
        2'd0:    return 8'hA0 | {5'b0, ch};
        2'd1:    return s;
        default: return {1'b0, ch, 4'h5};
      endcase
    end
  endfunction

endpackage

// File: rtl/ecgm_ctrl.sv
module ecgm_ctrl
  import ecgm_pkg::*;
#(
  parameter int SAMPLE_PERIOD = 5000,
  parameter int ENTER_LAT     = 300,
  parameter int WAKE_LAT      = 600
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     spiClk,
  input  logic     spiCsN,
  input  logic     spiMosi,
  output logic     dataReadyN,
  output ctrlStb_t stb
);
  localparam int SP_W    = $clog2(SAMPLE_PERIOD);
  localparam int LAT_MAX = (ENTER_LAT > WAKE_LAT) ? ENTER_LAT : WAKE_LAT;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  typedef enum logic [1:0] {PH_OP, PH_CNT, PH_RD, PH_WR} phase_e;

  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;
  logic csHigh, sclkRise, sclkFall, byteDone, opAccept, isRegOp, readyPulse;
  logic [7:0] rxByte;
  logic [6:0] rxSh;
  logic [2:0] bitCnt;
  phase_e phase;
  logic isRead, streaming;
  logic [ADDR_W-1:0] addr;
  logic [7:0] remain;
  logic [IDX_W-1:0] frameIdx;
  pwr_e pwr;
  logic [LAT_W-1:0] latCnt;
  logic [SP_W-1:0] spCnt;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], spiClk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], spiCsN};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], spiMosi};
    end

  always_comb begin
    csHigh     = csPipe[SYNC_STAGES-1];
    sclkRise   = sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
    sclkFall   = ~sclkPipe[SYNC_STAGES-1] & sclkPipe[SYNC_STAGES];
    rxByte     = {rxSh, mosiPipe[SYNC_STAGES-1]};
    byteDone   = !csHigh && sclkFall && (bitCnt == 3'd7);
    opAccept   = byteDone && (phase == PH_OP) && (pwr == PWR_ON);
    isRegOp    = (rxByte[7:5] == OP_RREG_HI) || (rxByte[7:5] == OP_WREG_HI);
    readyPulse = streaming && (pwr == PWR_ON) && (spCnt == SP_W'(SAMPLE_PERIOD - 1));
  end

  // serial framing and command sequencing
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxSh <= '0; bitCnt <= '0; phase <= PH_OP; isRead <= 1'b0;
      addr <= '0; remain <= '0; frameIdx <= '0; streaming <= 1'b0;
    end else if (csHigh) begin
      bitCnt <= '0; phase <= PH_OP; frameIdx <= '0;
    end else begin
      if (sclkFall) begin
        rxSh   <= rxByte[6:0];
        bitCnt <= bitCnt + 3'd1;
      end
      if (sclkRise && bitCnt == 3'd0 && phase == PH_OP && streaming &&
          frameIdx < IDX_W'(FRAME_BYTES))
        frameIdx <= frameIdx + IDX_W'(1);
      if (byteDone) begin
        unique case (phase)
          PH_OP: if (opAccept) begin
            if (isRegOp) begin
              addr   <= rxByte[ADDR_W-1:0];
              isRead <= (rxByte[7:5] == OP_RREG_HI);
              phase  <= PH_CNT;
            end else if (rxByte == OP_START)
              streaming <= 1'b1;
            else if (rxByte == OP_STOP || rxByte == OP_RESET)
              streaming <= 1'b0;
          end
          PH_CNT: begin
            remain <= rxByte;
            phase  <= isRead ? PH_RD : PH_WR;
          end
          default: begin
            addr <= addr + ADDR_W'(1);
            if (remain == 8'd0) phase <= PH_OP;
            else remain <= remain - 8'd1;
          end
        endcase
      end
    end

  // power state with entry and wake latencies
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      pwr <= PWR_ON; latCnt <= '0;
    end else begin
      unique case (pwr)
        PWR_ON: if (opAccept && rxByte == OP_SLEEP) begin
          pwr <= PWR_ENTER; latCnt <= LAT_W'(ENTER_LAT - 1);
        end
        PWR_SLEEP: if (byteDone && phase == PH_OP && rxByte == OP_WAKE) begin
          pwr <= PWR_WAKE; latCnt <= LAT_W'(WAKE_LAT - 1);
        end
        default: begin
          if (latCnt == '0) pwr <= (pwr == PWR_ENTER) ? PWR_SLEEP : PWR_ON;
          else latCnt <= latCnt - LAT_W'(1);
        end
      endcase
    end

  // sample period timer and data-ready strobe
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      spCnt <= '0; dataReadyN <= 1'b1;
    end else begin
      dataReadyN <= !readyPulse;
      if (!(streaming && pwr == PWR_ON) || readyPulse) spCnt <= '0;
      else spCnt <= spCnt + SP_W'(1);
    end

  always_comb begin
    stb            = '0;
    stb.csActive   = !csHigh;
    stb.loadTx     = !csHigh && sclkRise && (bitCnt == 3'd0);
    stb.shiftTx    = !csHigh && sclkRise && (bitCnt != 3'd0);
    stb.txSrc      = (phase == PH_RD) ? SRC_REG :
                     ((phase == PH_OP && streaming) ? SRC_FRAME : SRC_ZERO);
    stb.regAddr    = addr;
    stb.frameIdx   = frameIdx;
    stb.regWr      = byteDone && (phase == PH_WR);
    stb.wrData     = rxByte;
    stb.regReset   = opAccept && (rxByte == OP_RESET);
    stb.frameLatch = readyPulse;
    stb.sampleClr  = opAccept && (rxByte == OP_START || rxByte == OP_RESET);
  end

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dataReadyN |=> dataReadyN);
  p_ready_awake_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dataReadyN |-> $past(pwr) == PWR_ON);
  p_sleep_no_effect_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pwr == PWR_SLEEP || pwr == PWR_WAKE) |-> !(stb.regWr || stb.regReset || stb.sampleClr));
  p_cs_realign_r2: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (bitCnt == 3'd0) && (phase == PH_OP));

endmodule

// File: rtl/ecgm_dp.sv
module ecgm_dp
  import ecgm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  output logic     miso
);
  logic [7:0] regs [REG_COUNT];
  logic [7:0] sampleCnt, frameSample, txSh, txByte;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      for (int a = 0; a < REG_COUNT; a++) regs[a] <= regDefault(ADDR_W'(a));
    end else if (stb.regReset) begin
      for (int a = 0; a < REG_COUNT; a++) regs[a] <= regDefault(ADDR_W'(a));
    end else if (stb.regWr && stb.regAddr != '0 && int'(stb.regAddr) < REG_COUNT) begin
      regs[stb.regAddr] <= stb.wrData;
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sampleCnt <= '0; frameSample <= '0;
    end else if (stb.sampleClr) begin
      sampleCnt <= '0;
    end else if (stb.frameLatch) begin
      frameSample <= sampleCnt;
      sampleCnt   <= sampleCnt + 8'd1;
    end

  always_comb
    unique case (stb.txSrc)
      SRC_REG:   txByte = (int'(stb.regAddr) < REG_COUNT) ? regs[stb.regAddr] : 8'h00;
      SRC_FRAME: txByte = frameByte(stb.frameIdx, frameSample);
      default:   txByte = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             txSh <= '0;
    else if (!stb.csActive) txSh <= '0;
    else if (stb.loadTx)   txSh <= txByte;
    else if (stb.shiftTx)  txSh <= {txSh[6:0], 1'b0};

  assign miso = stb.csActive & txSh[7];

  p_id_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWr && stb.regAddr == '0) |=> regs[0] == ID_VALUE);
  p_default_restore_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.regReset |=> regs[REG_COUNT-1] == regDefault(ADDR_W'(REG_COUNT-1)));

endmodule

// File: rtl/ecgm_spi_mock.sv
module ecgm_spi_mock
  import ecgm_pkg::*;
#(
  parameter int SAMPLE_PERIOD = 5000,
  parameter int ENTER_LAT     = 300,
  parameter int WAKE_LAT      = 600
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiCsN,
  input  logic spiMosi,
  output logic spiMiso,
  output logic dataReadyN
);
  ctrlStb_t stb;

  ecgm_ctrl #(
    .SAMPLE_PERIOD(SAMPLE_PERIOD),
    .ENTER_LAT(ENTER_LAT),
    .WAKE_LAT(WAKE_LAT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .dataReadyN(dataReadyN), .stb(stb)
  );

  ecgm_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .miso(spiMiso)
  );

endmodule

// File: tb/test_ecgm_spi_mock.sv
module test_ecgm_spi_mock;
  localparam int SP = 5000, EL = 300, WL = 600, HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, dataReadyN;
  int nChecks = 0, nFails = 0, cyc = 0, falls = 0;
  logic [7:0] mdl [32];

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t expQ[$];
  logic [7:0] gotQ[$];

  ecgm_spi_mock #(.SAMPLE_PERIOD(SP), .ENTER_LAT(EL), .WAKE_LAT(WL)) i_ecgm_spi_mock (
    .clk(clk), .rstN(rstN), .spiClk(sclk), .spiCsN(csN), .spiMosi(mosi),
    .spiMiso(miso), .dataReadyN(dataReadyN));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge dataReadyN) if (rstN) falls++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (expQ.size() > 0 && gotQ.size() > 0) begin
      item_t e;
      logic [7:0] g;
      e = expQ.pop_front();
      g = gotQ.pop_front();
      chk(e.tag, 32'(g), 32'(e.v));
    end

  function automatic logic [7:0] defVal(int a);
    if (a == 0) return 8'hD2;
    if (a >= 26) return 8'h00;
    return 8'h40 | 8'(a);
  endfunction

  function automatic logic [7:0] frameExp(int k, int s);
    int ch, part;
    if (k == 0) return 8'hC0;
    if (k == 1) return 8'h00;
    if (k == 2) return 8'(s);
    if (k >= 27) return 8'h00;
    ch = (k - 3) / 3;
    part = (k - 3) % 3;
    if (part == 0) return 8'(8'hA0 + ch);
    if (part == 1) return 8'(s);
    return 8'(ch * 16 + 5);
  endfunction

  task automatic modelDefaults();
    for (int a = 0; a < 32; a++) mdl[a] = defVal(a);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); sclk = 1'b1; mosi = tx[b];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0; rx[b] = miso;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHighT();
    repeat (4) @(negedge clk); csN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    csLow(); xfer(op, d); csHighT();
  endtask

  task automatic wreg(input int a, input int n, input logic [7:0] base, input bit take);
    logic [7:0] d;
    csLow();
    xfer(8'h40 | 8'(a), d);
    xfer(8'(n - 1), d);
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = (a + i) % 32;
      xfer(8'(base + 8'(i * 7)), d);
      if (take && ad != 0 && ad < 26) mdl[ad] = 8'(base + 8'(i * 7));
    end
    csHighT();
  endtask

  task automatic rreg(input int a, input int n, input string tag);
    logic [7:0] d;
    csLow();
    xfer(8'h20 | 8'(a), d);
    xfer(8'(n - 1), d);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      gotQ.push_back(d);
      expQ.push_back('{mdl[(a + i) % 32], tag});
    end
    csHighT();
  endtask

  task automatic readFrame(input int s, input string tag);
    logic [7:0] d;
    csLow();
    for (int k = 0; k < 28; k++) begin
      xfer(8'h00, d);
      gotQ.push_back(d);
      expQ.push_back('{frameExp(k, s), tag});
    end
    csHighT();
  endtask

  task automatic finish();
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    int t1, t2, f0;
    logic [7:0] d;
    modelDefaults();
    repeat (5) @(negedge clk);
    chk("R1 ready idle in reset", 32'(dataReadyN), 32'd1);
    chk("R2 miso low in reset", 32'(miso), 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 ready idle after reset", 32'(dataReadyN), 32'd1);

    rreg(0, 26, "R1 defaults");

    wreg(3, 5, 8'h11, 1'b1);
    rreg(2, 7, "R3 burst write");
    wreg(10, 1, 8'h9C, 1'b1);
    rreg(10, 1, "R4 single read");

    wreg(0, 1, 8'h55, 1'b0);
    wreg(28, 1, 8'h99, 1'b0);
    rreg(0, 1, "R5 id read-only");
    rreg(24, 4, "R5 high addresses");

    // unknown opcode followed by a read in the same select
    csLow();
    xfer(8'h7F, d); xfer(8'h21, d); xfer(8'h00, d); xfer(8'h00, d);
    gotQ.push_back(d); expQ.push_back('{mdl[1], "R11 unknown opcode"});
    csHighT();

    // abandoned write: select rises before the data byte
    csLow(); xfer(8'h45, d); xfer(8'h00, d); csHighT();
    csLow(); xfer(8'h21, d); xfer(8'h00, d); xfer(8'h00, d);
    gotQ.push_back(d); expQ.push_back('{mdl[1], "R2 realign after select"});
    csHighT();
    rreg(5, 1, "R2 abandoned write");

    // continuous acquisition
    cmd(8'h10);
    @(negedge dataReadyN); t1 = cyc;
    @(posedge dataReadyN);
    chk("R7 pulse width", 32'(cyc - t1), 32'd1);
    @(negedge dataReadyN); t2 = cyc;
    chk("R7 period", 32'(t2 - t1), 32'(SP));
    readFrame(1, "R8 frame");
    @(negedge dataReadyN);
    readFrame(2, "R8 next frame");
    cmd(8'h11);
    f0 = falls;
    repeat (2 * SP) @(negedge clk);
    chk("R7 stop", 32'(falls), 32'(f0));

    // reset command
    wreg(7, 1, 8'h3C, 1'b1);
    rreg(7, 1, "R3 before reset");
    cmd(8'h10);
    @(negedge dataReadyN);
    cmd(8'h06);
    modelDefaults();
    rreg(3, 8, "R6 defaults restored");
    f0 = falls;
    repeat (2 * SP) @(negedge clk);
    chk("R6 acquisition stopped", 32'(falls), 32'(f0));

    // standby and wakeup
    cmd(8'h10);
    @(negedge dataReadyN);
    cmd(8'h04);
    f0 = falls;
    wreg(8, 1, 8'h5A, 1'b0);
    repeat (2 * SP) @(negedge clk);
    chk("R9 no pulses in standby", 32'(falls), 32'(f0));
    wreg(12, 1, 8'h6B, 1'b0);
    csLow(); xfer(8'h02, d);
    xfer(8'h49, d); xfer(8'h00, d); xfer(8'h66, d);
    csHighT();
    repeat (WL + 100) @(negedge clk);
    rreg(8, 1, "R9 write during entry");
    rreg(12, 1, "R9 write while asleep");
    rreg(9, 1, "R10 write while waking");
    f0 = falls;
    repeat (SP + 100) @(negedge clk);
    chk("R10 pulses resume", 32'(falls > f0), 32'd1);
    wreg(9, 1, 8'h66, 1'b1);
    rreg(9, 1, "R10 write after wake");
    cmd(8'h11);

    repeat (10) @(negedge clk);
    chk("R2 scoreboard drained", 32'(expQ.size() + gotQ.size()), 32'd0);
    finish();
  end

endmodule